// File: doc/BRIEF.md
# Debug Exception Cause Arbiter

This block sits beside the retire stage of a processor pipeline and decides, for each retiring instruction, whether a debug exception is taken and which cause is recorded. It looks at five debug sources at once: the instruction counter, a single instruction-address breakpoint, a data-breakpoint hit reported by the load/store unit, and the two encodings of the break instruction (wide and narrow). The sources are ranked by a fixed priority, and all of them are gated by the current interrupt level against the configured debug level and by a blocking bit left set after a previous exception.

On a taken exception the block raises a one-cycle take strobe and records the address of the triggering instruction, a one-hot cause value and the new low processor-status bits. It also owns the instruction counter and its level register. The counter is loaded by software and advances on each eligible retired instruction. It signals its exception when it holds all ones, which is one instruction before it would wrap, so a load of -2 lets exactly one instruction complete.

Top module: `dbg_cause_arb`

## Requirements
- R1: The recorded cause is one-hot on five bits: 0x01 instruction count, 0x02 instruction breakpoint, 0x04 data breakpoint, 0x08 wide break, 0x10 narrow break.
- R2: No exception is taken while `cur_lvl_i` is greater than or equal to `dbg_lvl_i`; a break instruction retiring then acts as a no-op.
- R3: `take_o` pulses high for one cycle in the cycle after the retiring instruction that caused it, and `epc_o` then holds that instruction's `pc_i`; `epc_o` and `cause_o` keep their values until the next take.
- R4: On a take, `ps_low_o` becomes 0x10 ORed with `dbg_lvl_i`; bit 4 stays set until `ps_clr_i` clears it (a take in the same cycle wins), bits 3:0 are kept.
- R5: While `ps_low_o` bit 4 is set, no exception is taken.
- R6: The instruction breakpoint fires only when `ib_en_i` is set and `pc_i` equals `ib_addr_i`.
- R7: Priority from highest to lowest is instruction count, instruction breakpoint, data breakpoint, wide break, narrow break.
- R8: The counter advances by one for each retired instruction with `cur_lvl_i` below the count level that takes no exception; a counter write in the same cycle wins.
- R9: The counter requests cause 0x01 when it is all ones at an eligible retire; that instruction does not advance it, so a load of -2 traps the second eligible instruction.
- R10: A count level of zero stops counting and never requests an exception.
- R11: When the counter is all ones at an eligible retire but the exception is gated off, the instruction retires and the counter wraps to zero.
- R12: After reset `take_o`, `epc_o`, `cause_o`, `ps_low_o`, the counter and the count level are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction is retiring this cycle |
| pc_i | input | PC_W | Address of the retiring instruction |
| wide_brk_i | input | 1 | Retiring instruction is the wide break |
| narrow_brk_i | input | 1 | Retiring instruction is the narrow break |
| ib_addr_i | input | PC_W | Instruction breakpoint address |
| ib_en_i | input | 1 | Instruction breakpoint enable |
| dbrk_hit_i | input | 1 | Data breakpoint matched for this instruction |
| cur_lvl_i | input | LVL_W | Current interrupt level |
| dbg_lvl_i | input | LVL_W | Configured debug level |
| cnt_wr_i | input | 1 | Load the instruction counter |
| cnt_wdata_i | input | CNT_W | Counter load value |
| clvl_wr_i | input | 1 | Load the count level |
| clvl_wdata_i | input | LVL_W | Count level load value |
| ps_clr_i | input | 1 | Clear the exception blocking bit |
| take_o | output | 1 | Debug exception taken (one-cycle strobe) |
| epc_o | output | PC_W | Saved address of the triggering instruction |
| cause_o | output | 5 | One-hot debug cause |
| ps_low_o | output | LVL_W+1 | Low processor-status bits |

## Verification
A corrupted counter shows at the ports only as a take that arrives early, late or never, possibly many instructions after the fault, so the bench loads values close to all ones and checks the exact instruction that traps and that a wrapped counter lets the next instruction pass. A wrong blocking bit or level compare shows within one cycle as a take that should not occur or a missing one. A wrong priority ranking shows on the next cycle as a different one-hot cause for coinciding sources, which is why several sources are driven together.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
    localparam int NCAUSE   = 5;
    // bit positions of the one-hot cause, lowest index = highest priority
    localparam int C_ICNT   = 0;
    localparam int C_IBRK   = 1;
    localparam int C_DBRK   = 2;
    localparam int C_WIDE   = 3;
    localparam int C_NARROW = 4;
    localparam int BLK_BIT  = 4;
endpackage

// File: rtl/dbg_icount.sv
module dbg_icount #(
    parameter int CNT_W = 32,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             lvl_wr_i,
    input  logic [LVL_W-1:0] lvl_wdata_i,
    input  logic             taken_i,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LVL_W-1:0] lvl;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    elig;

    always_comb begin
        st_d   = st_q;
        elig   = retire_i && (cur_lvl_i < st_q.lvl);
        fire_o = elig && (st_q.cnt == ALL_ONES);
        if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (elig && !taken_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (lvl_wr_i) begin
            st_d.lvl = lvl_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    lvl_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl == '0) |-> !fire_o);
    // R9
    hold_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && taken_i && !cnt_wr_i) |=> (st_q.cnt == $past(st_q.cnt)));
    // R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && (cur_lvl_i < st_q.lvl) && !taken_i && !cnt_wr_i)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/dbg_prio.sv
module dbg_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    always_comb begin
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    // R7
    always_comb begin
        grant_onehot_chk: assert (((grant_o & ~req_i) == '0) && $onehot0(grant_o)
                                  && ((req_i == '0) || (grant_o != '0)));
    end
endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
    import dbg_arb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int CNT_W = 32,
    parameter int LVL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               wide_brk_i,
    input  logic               narrow_brk_i,
    input  logic [PC_W-1:0]    ib_addr_i,
    input  logic               ib_en_i,
    input  logic               dbrk_hit_i,
    input  logic [LVL_W-1:0]   cur_lvl_i,
    input  logic [LVL_W-1:0]   dbg_lvl_i,
    input  logic               cnt_wr_i,
    input  logic [CNT_W-1:0]   cnt_wdata_i,
    input  logic               clvl_wr_i,
    input  logic [LVL_W-1:0]   clvl_wdata_i,
    input  logic               ps_clr_i,
    output logic               take_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [NCAUSE-1:0]  cause_o,
    output logic [LVL_W:0]     ps_low_o
);
    localparam int PS_W = LVL_W + 1;

    typedef struct packed {
        logic              take;
        logic [PC_W-1:0]   epc;
        logic [NCAUSE-1:0] cause;
        logic [PS_W-1:0]   ps;
    } arb_st_t;

    arb_st_t           st_d, st_q;
    logic [NCAUSE-1:0] req, grant;
    logic              icnt_fire, ib_hit, gate_open, take_now;

    dbg_icount #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_icnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_i   (retire_i),
        .cur_lvl_i  (cur_lvl_i),
        .cnt_wr_i   (cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i),
        .lvl_wr_i   (clvl_wr_i),
        .lvl_wdata_i(clvl_wdata_i),
        .taken_i    (take_now),
        .fire_o     (icnt_fire)
    );

    dbg_prio #(.N(NCAUSE)) u_prio (
        .req_i  (req),
        .grant_o(grant)
    );

    always_comb begin
        ib_hit          = retire_i && ib_en_i && (pc_i == ib_addr_i);
        req             = '0;
        req[C_ICNT]     = icnt_fire;
        req[C_IBRK]     = ib_hit;
        req[C_DBRK]     = retire_i && dbrk_hit_i;
        req[C_WIDE]     = retire_i && wide_brk_i;
        req[C_NARROW]   = retire_i && narrow_brk_i;
        gate_open       = (cur_lvl_i < dbg_lvl_i) && !st_q.ps[BLK_BIT];
        take_now        = gate_open && (req != '0);

        st_d      = st_q;
        st_d.take = take_now;
        if (take_now) begin
            st_d.epc   = pc_i;
            st_d.cause = grant;
            st_d.ps    = {1'b1, dbg_lvl_i};
        end else if (ps_clr_i) begin
            st_d.ps[BLK_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o   = st_q.take;
    assign epc_o    = st_q.epc;
    assign cause_o  = st_q.cause;
    assign ps_low_o = st_q.ps;

    // R1
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(cause_o) == 1));
    // R2
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(cur_lvl_i) < $past(dbg_lvl_i)));
    // R3
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (epc_o == $past(pc_i)) && $past(retire_i));
    // R4
    ps_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (ps_low_o == {1'b1, $past(dbg_lvl_i)}));
    // R5
    blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_low_o[BLK_BIT] |=> !take_o);
    // R6
    ibrk_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && ib_hit && !icnt_fire) |=> (cause_o == 5'h02));
endmodule

// File: tb/sim_dbg_cause_arb.sv
module sim_dbg_cause_arb;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32, CNT_W = 32, LVL_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic retire = 0, wide = 0, narrow = 0, ib_en = 0, dbrk = 0;
    logic cnt_wr = 0, clvl_wr = 0, ps_clr = 0;
    logic [PC_W-1:0] pc = '0, ib_addr = '0;
    logic [LVL_W-1:0] cur_lvl = '0, dbg_lvl = 4'd3, clvl_wdata = '0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic take;
    logic [PC_W-1:0] epc;
    logic [4:0] cause;
    logic [LVL_W:0] ps_low;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [CNT_W-1:0] m_cnt = '0;
    int m_clvl = 0;
    int m_ps = 0;
    bit m_take = 0;
    logic [PC_W-1:0] m_epc = '0;
    int m_cause = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cause_arb #(.PC_W(PC_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .pc_i(pc),
        .wide_brk_i(wide), .narrow_brk_i(narrow), .ib_addr_i(ib_addr),
        .ib_en_i(ib_en), .dbrk_hit_i(dbrk), .cur_lvl_i(cur_lvl),
        .dbg_lvl_i(dbg_lvl), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
        .clvl_wr_i(clvl_wr), .clvl_wdata_i(clvl_wdata), .ps_clr_i(ps_clr),
        .take_o(take), .epc_o(epc), .cause_o(cause), .ps_low_o(ps_low)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 take", take, m_take);
        chk("R3 epc", epc, m_epc);
        chk("R1 cause", cause, m_cause);
        chk("R4 ps", ps_low, m_ps);
    endtask

    // advance model with the current inputs, clock once, compare at negedge
    task automatic tick();
        bit elig, ireq, ibhit, tk;
        int c;
        elig  = retire && (int'(cur_lvl) < m_clvl);
        ireq  = elig && (m_cnt == '1);
        ibhit = retire && ib_en && (pc == ib_addr);
        if (ireq) c = 1;
        else if (ibhit) c = 2;
        else if (retire && dbrk) c = 4;
        else if (retire && wide) c = 8;
        else if (retire && narrow) c = 16;
        else c = 0;
        tk = (cur_lvl < dbg_lvl) && ((m_ps & 16) == 0) && (c != 0);
        if (cnt_wr) m_cnt = cnt_wdata;
        else if (elig && !tk) m_cnt = m_cnt + 1;
        if (clvl_wr) m_clvl = int'(clvl_wdata);
        m_take = tk;
        if (tk) begin
            m_epc = pc; m_cause = c; m_ps = 16 | int'(dbg_lvl);
        end else if (ps_clr) m_ps = m_ps & 15;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        retire = 0; wide = 0; narrow = 0; dbrk = 0; cnt_wr = 0; clvl_wr = 0; ps_clr = 0;
    endtask

    task automatic instr(input logic [PC_W-1:0] a, input bit w, input bit n, input bit d);
        retire = 1; pc = a; wide = w; narrow = n; dbrk = d;
        tick();
        idle();
    endtask

    task automatic clr_ps();
        ps_clr = 1; tick(); idle();
    endtask

    task automatic load_cnt(input logic [CNT_W-1:0] v, input logic [LVL_W-1:0] l);
        cnt_wr = 1; cnt_wdata = v; clvl_wr = 1; clvl_wdata = l; tick(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R12 reset state
        chk("R12 take", take, 0); chk("R12 cause", cause, 0);
        chk("R12 ps", ps_low, 0); chk("R12 epc", epc, 0);
        // R10/R12: counter level zero after reset, all-ones counter never traps
        cnt_wr = 1; cnt_wdata = '1; tick(); idle();
        instr(32'h100, 0, 0, 0);
        chk("R10 no trap at level 0", take, 0);

        // R2: break at debug level is a no-op
        dbg_lvl = 4'd3; cur_lvl = 4'd3;
        instr(32'h200, 1, 0, 0);
        chk("R2 gated break", take, 0);
        cur_lvl = 4'd2;
        instr(32'h204, 1, 0, 0);
        chk("R1 wide cause", cause, 5'h08); chk("R3 epc", epc, 32'h204);
        chk("R4 ps", ps_low, 5'h13);
        // R5: blocked until cleared
        instr(32'h208, 0, 1, 0);
        chk("R5 blocked", take, 0);
        clr_ps();
        chk("R4 clear keeps level", ps_low, 5'h03);
        instr(32'h20a, 0, 1, 0);
        chk("R1 narrow cause", cause, 5'h10);
        clr_ps();

        // R6: breakpoint disabled, then enabled beats break
        ib_addr = 32'h300; ib_en = 0;
        instr(32'h300, 0, 0, 0);
        chk("R6 disabled", take, 0);
        ib_en = 1;
        instr(32'h304, 0, 0, 0);
        chk("R6 addr mismatch", take, 0);
        instr(32'h300, 1, 0, 0);
        chk("R6 ibreak over break", cause, 5'h02);
        clr_ps();
        ib_en = 0;
        // R7: data breakpoint over wide break
        instr(32'h310, 1, 1, 1);
        chk("R7 dbreak first", cause, 5'h04);
        clr_ps();

        // R9: load -2, second eligible instruction traps
        cur_lvl = 0;
        load_cnt(-32'sd2, 4'd1);
        instr(32'h400, 0, 0, 0);
        chk("R9 first completes", take, 0);
        ib_en = 1; ib_addr = 32'h404;
        instr(32'h404, 1, 0, 0);
        chk("R7 icount highest", cause, 5'h01); chk("R9 epc", epc, 32'h404);
        ib_en = 0;
        clr_ps();
        // counter was held at all ones: next eligible instruction traps again
        instr(32'h408, 0, 0, 0);
        chk("R9 held at ones", cause, 5'h01);
        clr_ps();

        // R8: no counting at or above the count level
        load_cnt(-32'sd2, 4'd2);
        cur_lvl = 2;
        repeat (3) instr(32'h500, 0, 0, 0);
        chk("R8 not counted", take, 0);
        cur_lvl = 1;
        instr(32'h504, 0, 0, 0);
        chk("R8 counted once", take, 0);
        instr(32'h508, 0, 0, 0);
        chk("R8 trap after count", cause, 5'h01);
        clr_ps();

        // R11: gated overflow wraps
        load_cnt('1, 4'd8);
        cur_lvl = 5;
        instr(32'h600, 0, 0, 0);
        chk("R11 gated", take, 0);
        cur_lvl = 0;
        instr(32'h604, 0, 0, 0);
        chk("R11 wrapped no trap", take, 0);
        // R10: level write to zero stops counting
        load_cnt('1, 4'd0);
        repeat (4) instr(32'h700, 0, 0, 0);
        chk("R10 stopped", take, 0);

        // mixed stimulus compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            retire  = $urandom_range(0, 1);
            pc      = {28'h0, 4'($urandom_range(0, 7))};
            wide    = ($urandom_range(0, 5) == 0);
            narrow  = ($urandom_range(0, 5) == 0);
            dbrk    = ($urandom_range(0, 7) == 0);
            ib_en   = $urandom_range(0, 1);
            ib_addr = {28'h0, 4'($urandom_range(0, 7))};
            cur_lvl = 4'($urandom_range(0, 6));
            dbg_lvl = 4'($urandom_range(1, 6));
            ps_clr  = ($urandom_range(0, 2) == 0);
            cnt_wr  = ($urandom_range(0, 15) == 0);
            cnt_wdata = '1 - CNT_W'($urandom_range(0, 4));
            clvl_wr = ($urandom_range(0, 15) == 0);
            clvl_wdata = 4'($urandom_range(0, 7));
            tick();
        end
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule